// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a processor that runs each instruction over several clock cycles and shares one memory and one ALU between all of those cycles. A one-hot state machine walks every instruction through a common fetch cycle and a common decode cycle. Then, depending on the instruction class, it takes an execute, memory and register write-back path of its own. In every state it drives every datapath control line: the register write enables, the memory and register-file write enables, and the mux selects and ALU operation.

The datapath feeds back the opcode and function field held in its instruction register. It also feeds back one flag that says whether operands A and B are equal. Register-type, load, store, add-immediate, branch-if-equal and jump instructions are supported. An instruction takes between two and five cycles, depending on its class. Any control line that a state does not use is held at zero. Zero means not written, or the first mux input, or add.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is the fetch state, whatever state the machine was in. The `state` port has one bit per state: bit 0 fetch, 1 decode, 2 address execute, 3 register execute, 4 immediate execute, 5 branch execute, 6 memory read, 7 memory write, 8 load write-back, 9 register write-back, 10 immediate write-back.
- R2: After reset, exactly one bit of `state` is set in every cycle.
- R3: The fetch state asserts `ir_we` and `pc_we`. It selects the PC as the memory address (`mem_addr_sel`=0) and as ALU operand A (`alu_a_sel`=0), the constant four as ALU operand B (`alu_b_sel`=1), and the ALU output as the PC source (`pc_src_sel`=0). It requests add (`alu_op`=0). The next state is always decode.
- R4: In the decode state, `a_we` and `b_we` are asserted for every opcode except jump (0x02). The opcodes are 0x00 register type, 0x23 load, 0x2B store, 0x04 branch-if-equal, 0x02 jump and 0x08 add-immediate.
- R5: For a jump, the decode state asserts `pc_we` with `pc_src_sel`=2 (the jump target). The instruction then returns to fetch, so it takes 2 cycles.
- R6: For branch-if-equal, the decode state computes PC plus the shifted immediate into the result register. This uses `res_we`, `alu_a_sel`=0 and `alu_b_sel`=3. In the branch execute state the unit requests subtract (`alu_op`=1) on A and B and sets `pc_src_sel`=1 (the result register). It asserts `pc_we` only if `opnd_equal` is 1. It then returns to fetch, so the instruction takes 3 cycles.
- R7: A load runs fetch, decode, address execute, memory read and load write-back (5 cycles). Address execute writes A plus the immediate (`alu_a_sel`=1, `alu_b_sel`=2, `res_we`). Memory read asserts `mdr_we` with `mem_addr_sel`=1. Load write-back asserts `rf_we` with `rf_dst_sel`=0 (rt) and `rf_wdata_sel`=1 (data register).
- R8: A store runs fetch, decode, address execute and memory write (4 cycles). Memory write asserts `mem_we` with `mem_addr_sel`=1. A store never asserts `rf_we`.
- R9: A register-type instruction runs fetch, decode, register execute and register write-back (4 cycles). Register execute asserts `res_we` with `alu_a_sel`=1 and `alu_b_sel`=0. Register write-back asserts `rf_we` with `rf_dst_sel`=1 (rd) and `rf_wdata_sel`=0 (result).
- R10: An add-immediate runs fetch, decode, immediate execute and immediate write-back (4 cycles). Immediate execute adds A and the immediate into the result register. Immediate write-back asserts `rf_we` with `rf_dst_sel`=0 and `rf_wdata_sel`=0.
- R11: An unknown opcode goes from decode straight back to fetch. Apart from `a_we` and `b_we` in decode, it writes nothing.
- R12: In register execute, `alu_op` follows the function field: 0x20 gives add (0), 0x22 subtract (1), 0x24 and (2), 0x25 or (3), 0x2A set-less-than (4). Any other function code gives add.
- R13: `mem_we` is asserted only with `mem_addr_sel`=1, and `ir_we` only with `mem_addr_sel`=0. `mem_we` and `rf_we` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | OPC_W (6) | Opcode field from the instruction register |
| funct | input | FN_W (6) | Function field from the instruction register |
| opnd_equal | input | 1 | Datapath flag: operand A equals operand B |
| state | output | 11 | One-hot current state |
| pc_we | output | 1 | PC write enable |
| ir_we | output | 1 | Instruction register write enable |
| a_we | output | 1 | Operand A register write enable |
| b_we | output | 1 | Operand B register write enable |
| res_we | output | 1 | Result register write enable |
| mdr_we | output | 1 | Memory data register write enable |
| mem_we | output | 1 | Memory write enable |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| rf_wdata_sel | output | 1 | Register write data: 0 result, 1 data register |
| pc_src_sel | output | 2 | PC source: 0 ALU, 1 result register, 2 jump target |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 result register |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU operand B: 0 B, 1 four, 2 immediate, 3 immediate shifted by two |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 slt |

## Verification
Some rules hold on every cycle, and the assertions check those: the one-hot invariant, reset forcing fetch, fetch always leading to decode, and jump and unknown opcodes leaving decode for fetch. They also check that PC writes in branch execute follow the equality flag, and that the memory and instruction-register writes stay tied to the right address source. Only the bench scenarios can show the full per-class sequences and their cycle counts. They also cover the exact control vector in each state, the function-field mapping including an unknown code, both branch outcomes, and a reset taken in the middle of an instruction.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared state indices, select encodings, ALU operation codes,
// instruction classes and the bundled control-word type of the sequencer.
// Assumes a 6-bit opcode and a 6-bit function field in their usual meaning.
package mc_ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    // One-hot state indices; the order is the bit order of the state port
    localparam int S_FETCH   = 0;
    localparam int S_DECODE  = 1;
    localparam int S_EX_ADDR = 2;
    localparam int S_EX_REG  = 3;
    localparam int S_EX_IMM  = 4;
    localparam int S_EX_BR   = 5;
    localparam int S_MEM_RD  = 6;
    localparam int S_MEM_WR  = 7;
    localparam int S_WB_LOAD = 8;
    localparam int S_WB_REG  = 9;
    localparam int S_WB_IMM  = 10;
    localparam int N_ST      = 11;

    typedef logic [N_ST-1:0] st_vec_t;

    // Opcode values
    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_ADDI  = 6'h08;

    // Function field values
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_REG, CL_LOAD, CL_STORE, CL_BEQ, CL_JUMP, CL_ADDI, CL_BAD
    } instr_class_e;

    // Mux select encodings
    localparam logic [1:0] PCS_ALU  = 2'd0;
    localparam logic [1:0] PCS_RES  = 2'd1;
    localparam logic [1:0] PCS_JMP  = 2'd2;
    localparam logic [1:0] ALUB_B   = 2'd0;
    localparam logic [1:0] ALUB_FOUR = 2'd1;
    localparam logic [1:0] ALUB_IMM = 2'd2;
    localparam logic [1:0] ALUB_IMM4 = 2'd3;
    localparam logic       ADDR_PC  = 1'b0;
    localparam logic       ADDR_RES = 1'b1;
    localparam logic       ALUA_PC  = 1'b0;
    localparam logic       ALUA_A   = 1'b1;
    localparam logic       DST_RT   = 1'b0;
    localparam logic       DST_RD   = 1'b1;
    localparam logic       WD_RES   = 1'b0;
    localparam logic       WD_MDR   = 1'b1;

    typedef struct packed {
        logic       pc_we;
        logic       ir_we;
        logic       a_we;
        logic       b_we;
        logic       res_we;
        logic       mdr_we;
        logic       mem_we;
        logic       rf_we;
        logic       dst_sel;
        logic       wdata_sel;
        logic [1:0] pc_src;
        logic       addr_sel;
        logic       alua_sel;
        logic [1:0] alub_sel;
        alu_op_e    alu_op;
    } ctl_t;

endpackage

// File: rtl/mc_ctrl_decode.sv
// Module: instruction classifier. Maps the opcode to an instruction class and
// the function field to an ALU operation for register-type instructions.
// Assumes both fields are held stable by the instruction register after fetch.
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
#(
    parameter int OPC_W = mc_ctrl_pkg::OPC_W,
    parameter int FN_W  = mc_ctrl_pkg::FN_W
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output instr_class_e     cls,
    output alu_op_e          fn_op
);

    // Classify the opcode; anything unlisted is marked bad
    always_comb begin
        unique case (opcode)
            OPC_W'(OP_REG):   cls = CL_REG;
            OPC_W'(OP_LOAD):  cls = CL_LOAD;
            OPC_W'(OP_STORE): cls = CL_STORE;
            OPC_W'(OP_BEQ):   cls = CL_BEQ;
            OPC_W'(OP_JUMP):  cls = CL_JUMP;
            OPC_W'(OP_ADDI):  cls = CL_ADDI;
            default:          cls = CL_BAD;
        endcase
    end

    // Map the function field to an ALU operation, add by default
    always_comb begin
        unique case (funct)
            FN_W'(FN_SUB): fn_op = ALU_SUB;
            FN_W'(FN_AND): fn_op = ALU_AND;
            FN_W'(FN_OR):  fn_op = ALU_OR;
            FN_W'(FN_SLT): fn_op = ALU_SLT;
            default:       fn_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_state.sv
// Module: one-hot state register and next-state logic. Each instruction class
// leaves the shared fetch/decode front end for its own execute, memory and
// write-back path. Assumes the class is valid from the decode state onward.
module mc_ctrl_state
    import mc_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  instr_class_e cls,
    output st_vec_t      state_q
);

    localparam st_vec_t ONE_FETCH = st_vec_t'(1) << S_FETCH;

    st_vec_t state_d;

    // Compute the successor of the single active state bit
    always_comb begin
        state_d = '0;
        if (state_q[S_FETCH]) state_d[S_DECODE] = 1'b1;
        if (state_q[S_DECODE]) begin
            case (cls)
                CL_REG:            state_d[S_EX_REG]  = 1'b1;
                CL_LOAD, CL_STORE: state_d[S_EX_ADDR] = 1'b1;
                CL_ADDI:           state_d[S_EX_IMM]  = 1'b1;
                CL_BEQ:            state_d[S_EX_BR]   = 1'b1;
                default:           state_d[S_FETCH]   = 1'b1;
            endcase
        end
        if (state_q[S_EX_ADDR]) begin
            if (cls == CL_STORE) state_d[S_MEM_WR] = 1'b1;
            else                 state_d[S_MEM_RD] = 1'b1;
        end
        if (state_q[S_EX_REG])  state_d[S_WB_REG]  = 1'b1;
        if (state_q[S_EX_IMM])  state_d[S_WB_IMM]  = 1'b1;
        if (state_q[S_MEM_RD])  state_d[S_WB_LOAD] = 1'b1;
        if (state_q[S_EX_BR] || state_q[S_MEM_WR] || state_q[S_WB_LOAD] ||
            state_q[S_WB_REG] || state_q[S_WB_IMM])
            state_d[S_FETCH] = 1'b1;
    end

    // Hold the state, forcing fetch on synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ONE_FETCH;
        else        state_q <= state_d;
    end

    // R1: reset always lands in fetch
    a_r1_reset_fetch: assert property (@(posedge clk)
        !rst_n |=> state_q == ONE_FETCH);

    // R2: exactly one state bit is active
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    // R3: fetch is always followed by decode
    a_r3_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[S_FETCH] |=> state_q[S_DECODE]);

    // R5 and R11: jump and unknown opcodes end in decode
    a_r5_jump_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q[S_DECODE] && (cls == CL_JUMP || cls == CL_BAD)) |=> state_q[S_FETCH]);

endmodule

// File: rtl/mc_ctrl_outputs.sv
// Module: control-word generator. Produces every datapath control line from
// the one-hot state, the instruction class, the function-field ALU operation
// and the operand-equal flag. Unused lines in a state stay at zero.
module mc_ctrl_outputs
    import mc_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  st_vec_t      state_q,
    input  instr_class_e cls,
    input  alu_op_e      fn_op,
    input  logic         opnd_equal,
    output ctl_t         ctl
);

    // Build the control word for the active state
    always_comb begin
        ctl = '0;
        if (state_q[S_FETCH]) begin
            ctl.ir_we    = 1'b1;
            ctl.pc_we    = 1'b1;
            ctl.addr_sel = ADDR_PC;
            ctl.alua_sel = ALUA_PC;
            ctl.alub_sel = ALUB_FOUR;
            ctl.pc_src   = PCS_ALU;
            ctl.alu_op   = ALU_ADD;
        end
        if (state_q[S_DECODE]) begin
            if (cls == CL_JUMP) begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end else begin
                ctl.a_we = 1'b1;
                ctl.b_we = 1'b1;
                if (cls == CL_BEQ) begin
                    ctl.res_we   = 1'b1;
                    ctl.alua_sel = ALUA_PC;
                    ctl.alub_sel = ALUB_IMM4;
                    ctl.alu_op   = ALU_ADD;
                end
            end
        end
        if (state_q[S_EX_ADDR] || state_q[S_EX_IMM]) begin
            ctl.res_we   = 1'b1;
            ctl.alua_sel = ALUA_A;
            ctl.alub_sel = ALUB_IMM;
            ctl.alu_op   = ALU_ADD;
        end
        if (state_q[S_EX_REG]) begin
            ctl.res_we   = 1'b1;
            ctl.alua_sel = ALUA_A;
            ctl.alub_sel = ALUB_B;
            ctl.alu_op   = fn_op;
        end
        if (state_q[S_EX_BR]) begin
            ctl.alua_sel = ALUA_A;
            ctl.alub_sel = ALUB_B;
            ctl.alu_op   = ALU_SUB;
            ctl.pc_src   = PCS_RES;
            ctl.pc_we    = opnd_equal;
        end
        if (state_q[S_MEM_RD]) begin
            ctl.addr_sel = ADDR_RES;
            ctl.mdr_we   = 1'b1;
        end
        if (state_q[S_MEM_WR]) begin
            ctl.addr_sel = ADDR_RES;
            ctl.mem_we   = 1'b1;
        end
        if (state_q[S_WB_LOAD]) begin
            ctl.rf_we     = 1'b1;
            ctl.dst_sel   = DST_RT;
            ctl.wdata_sel = WD_MDR;
        end
        if (state_q[S_WB_REG]) begin
            ctl.rf_we     = 1'b1;
            ctl.dst_sel   = DST_RD;
            ctl.wdata_sel = WD_RES;
        end
        if (state_q[S_WB_IMM]) begin
            ctl.rf_we     = 1'b1;
            ctl.dst_sel   = DST_RT;
            ctl.wdata_sel = WD_RES;
        end
    end

    // R6: branch execute writes PC exactly when operands match
    a_r6_branch_pc: assert property (@(posedge clk) disable iff (!rst_n)
        state_q[S_EX_BR] |-> (ctl.pc_we == opnd_equal && ctl.pc_src == PCS_RES));

    // R13: memory writes use the result address
    a_r13_mem_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_we |-> ctl.addr_sel == ADDR_RES);

    // R13: instruction loads use the PC address
    a_r13_ir_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ir_we |-> ctl.addr_sel == ADDR_PC);

    // R13: never write memory and register file together
    a_r13_no_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.mem_we && ctl.rf_we));

    // R8: a store never writes the register file
    a_r8_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CL_STORE && !state_q[S_FETCH]) |-> !ctl.rf_we);

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Module: top of the multi-cycle control sequencer. Ties the classifier, the
// one-hot state machine and the control-word generator together and spreads
// the control word onto individual ports. Assumes opcode and funct come from
// the instruction register and opnd_equal from the datapath comparator.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int OPC_W = mc_ctrl_pkg::OPC_W,
    parameter int FN_W  = mc_ctrl_pkg::FN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             opnd_equal,
    output logic [N_ST-1:0]  state,
    output logic             pc_we,
    output logic             ir_we,
    output logic             a_we,
    output logic             b_we,
    output logic             res_we,
    output logic             mdr_we,
    output logic             mem_we,
    output logic             rf_we,
    output logic             rf_dst_sel,
    output logic             rf_wdata_sel,
    output logic [1:0]       pc_src_sel,
    output logic             mem_addr_sel,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [2:0]       alu_op
);

    instr_class_e cls;
    alu_op_e      fn_op;
    st_vec_t      state_q;
    ctl_t         ctl;

    mc_ctrl_decode #(.OPC_W(OPC_W), .FN_W(FN_W)) u_decode (
        .opcode (opcode),
        .funct  (funct),
        .cls    (cls),
        .fn_op  (fn_op)
    );

    mc_ctrl_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls     (cls),
        .state_q (state_q)
    );

    mc_ctrl_outputs u_outputs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .cls        (cls),
        .fn_op      (fn_op),
        .opnd_equal (opnd_equal),
        .ctl        (ctl)
    );

    // Spread the control word onto the ports
    always_comb begin
        state        = state_q;
        pc_we        = ctl.pc_we;
        ir_we        = ctl.ir_we;
        a_we         = ctl.a_we;
        b_we         = ctl.b_we;
        res_we       = ctl.res_we;
        mdr_we       = ctl.mdr_we;
        mem_we       = ctl.mem_we;
        rf_we        = ctl.rf_we;
        rf_dst_sel   = ctl.dst_sel;
        rf_wdata_sel = ctl.wdata_sel;
        pc_src_sel   = ctl.pc_src;
        mem_addr_sel = ctl.addr_sel;
        alu_a_sel    = ctl.alua_sel;
        alu_b_sel    = ctl.alub_sel;
        alu_op       = ctl.alu_op;
    end

endmodule

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic        opnd_equal;
    logic [10:0] state;
    logic        pc_we, ir_we, a_we, b_we, res_we, mdr_we, mem_we, rf_we;
    logic        rf_dst_sel, rf_wdata_sel, mem_addr_sel, alu_a_sel;
    logic [1:0]  pc_src_sel, alu_b_sel;
    logic [2:0]  alu_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [29:0] v;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    mc_ctrl_fsm dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
        .opnd_equal(opnd_equal), .state(state), .pc_we(pc_we), .ir_we(ir_we),
        .a_we(a_we), .b_we(b_we), .res_we(res_we), .mdr_we(mdr_we),
        .mem_we(mem_we), .rf_we(rf_we), .rf_dst_sel(rf_dst_sel),
        .rf_wdata_sel(rf_wdata_sel), .pc_src_sel(pc_src_sel),
        .mem_addr_sel(mem_addr_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op)
    );

    // Expected control vector: state, 8 enables, dst, wdata, pcsrc, addr, asel, bsel, op
    function automatic logic [29:0] mk(input int st, input logic [7:0] we,
                                       input logic dst, input logic wd,
                                       input logic [1:0] pcs, input logic addr,
                                       input logic asel, input logic [1:0] bsel,
                                       input logic [2:0] op);
        logic [10:0] s;
        s = 11'(1) << st;
        return {s, we, dst, wd, pcs, addr, asel, bsel, op};
    endfunction

    function automatic logic [2:0] fn_to_op(input logic [5:0] fn);
        case (fn)
            6'h22:   return 3'd1;
            6'h24:   return 3'd2;
            6'h25:   return 3'd3;
            6'h2A:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [29:0] e_fetch();
        return mk(0, 8'b1100_0000, 0, 0, 2'd0, 0, 0, 2'd1, 3'd0);
    endfunction

    task automatic push(input logic [29:0] v, input string req);
        exp_t e;
        e.v = v;
        e.req = req;
        sb_q.push_back(e);
    endtask

    // Driver: set inputs, queue the expected per-cycle vectors, run the cycles
    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn,
                             input logic eq, input string req);
        int n;
        opcode = op;
        funct = fn;
        opnd_equal = eq;
        push(e_fetch(), {req, "/R3"});
        case (op)
            6'h00: begin
                push(mk(1, 8'b0011_0000, 0, 0, 0, 0, 0, 0, 0), {req, "/R4"});
                push(mk(3, 8'b0000_1000, 0, 0, 0, 0, 1, 0, fn_to_op(fn)), {req, "/R12"});
                push(mk(9, 8'b0000_0001, 1, 0, 0, 0, 0, 0, 0), req);
                n = 4;
            end
            6'h23: begin
                push(mk(1, 8'b0011_0000, 0, 0, 0, 0, 0, 0, 0), {req, "/R4"});
                push(mk(2, 8'b0000_1000, 0, 0, 0, 0, 1, 2, 0), req);
                push(mk(6, 8'b0000_0100, 0, 0, 0, 1, 0, 0, 0), req);
                push(mk(8, 8'b0000_0001, 0, 1, 0, 0, 0, 0, 0), req);
                n = 5;
            end
            6'h2B: begin
                push(mk(1, 8'b0011_0000, 0, 0, 0, 0, 0, 0, 0), {req, "/R4"});
                push(mk(2, 8'b0000_1000, 0, 0, 0, 0, 1, 2, 0), req);
                push(mk(7, 8'b0000_0010, 0, 0, 0, 1, 0, 0, 0), {req, "/R13"});
                n = 4;
            end
            6'h04: begin
                push(mk(1, 8'b0011_1000, 0, 0, 0, 0, 0, 3, 0), req);
                push(mk(5, eq ? 8'b1000_0000 : 8'b0, 0, 0, 1, 0, 1, 0, 1), req);
                n = 3;
            end
            6'h02: begin
                push(mk(1, 8'b1000_0000, 0, 0, 2, 0, 0, 0, 0), req);
                n = 2;
            end
            6'h08: begin
                push(mk(1, 8'b0011_0000, 0, 0, 0, 0, 0, 0, 0), {req, "/R4"});
                push(mk(4, 8'b0000_1000, 0, 0, 0, 0, 1, 2, 0), req);
                push(mk(10, 8'b0000_0001, 0, 0, 0, 0, 0, 0, 0), req);
                n = 4;
            end
            default: begin
                push(mk(1, 8'b0011_0000, 0, 0, 0, 0, 0, 0, 0), req);
                n = 2;
            end
        endcase
        // Followed by a fresh fetch: proves the cycle count (R2 one-hot per vector)
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: compare outputs against queued expectations between edges
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [29:0] got;
            e = sb_q.pop_front();
            got = {state, pc_we, ir_we, a_we, b_we, res_we, mdr_we, mem_we, rf_we,
                   rf_dst_sel, rf_wdata_sel, pc_src_sel, mem_addr_sel, alu_a_sel,
                   alu_b_sel, alu_op};
            checks++;
            if (got !== e.v) begin
                errors++;
                $display("FAIL %s: got %h expected %h", e.req, got, e.v);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        opcode = 6'h00;
        funct = 6'h20;
        opnd_equal = 1'b0;
        @(posedge clk);
        #1;
        push(e_fetch(), "R1 reset state");
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        run_instr(6'h00, 6'h20, 0, "R9 add");
        run_instr(6'h00, 6'h22, 0, "R9 sub");
        run_instr(6'h00, 6'h24, 0, "R12 and");
        run_instr(6'h00, 6'h25, 1, "R12 or");
        run_instr(6'h00, 6'h2A, 0, "R12 slt");
        run_instr(6'h00, 6'h3F, 0, "R12 unknown funct");
        run_instr(6'h23, 6'h00, 0, "R7 load");
        run_instr(6'h2B, 6'h00, 1, "R8 store");
        run_instr(6'h04, 6'h00, 1, "R6 beq taken");
        run_instr(6'h04, 6'h00, 0, "R6 beq not taken");
        run_instr(6'h02, 6'h00, 1, "R5 jump");
        run_instr(6'h08, 6'h00, 0, "R10 addi");
        run_instr(6'h3F, 6'h00, 0, "R11 unknown opcode");
        run_instr(6'h23, 6'h00, 0, "R7 load again");

        // R1: reset in the middle of a load returns to fetch
        opcode = 6'h23;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        push(e_fetch(), "R1 mid-instruction reset");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        run_instr(6'h02, 6'h00, 0, "R5 jump after reset");

        @(negedge clk);
        #1;
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 scoreboard: got %0d pending expected 0", sb_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule